// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of a one-instruction-per-clock processor. It is purely combinational. It looks at the 6-bit major opcode, the 6-bit function field and the ALU zero flag, and produces every select and enable the datapath needs for the instruction now in flight. Those outputs are the next-PC source, the source of the register write address, the two ALU operand sources, the write-back source, the ALU operation, the register-file write enable and the data-memory write strobe.

Register-format instructions (major opcode 000000) are decoded from their function field. All other instructions are decoded from the major opcode alone. Branches use an ALU subtraction, and the zero flag decides whether the branch target or the sequential PC is chosen. Any encoding outside the supported set becomes an illegal-instruction trap. The trap sends the PC to the exception vector and saves the return address (PC+4) in register 27.

Output codes:
- pc_sel_o: 0 = PC+4, 1 = branch target, 2 = jump target, 3 = register, 4 = exception vector.
- wa_sel_o: 0 = Rd, 1 = Rt, 2 = register 31, 3 = register 27.
- a_sel_o: 0 = Rs data, 1 = shamt, 2 = constant 16.
- b_sel_o: 0 = Rt data, 1 = sign-extended immediate.
- wd_sel_o: 0 = PC+4, 1 = ALU result, 2 = memory data.
- alu_fn_o: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 shift left, 7 logical shift right, 8 arithmetic shift right, 9 signed less-than, 10 unsigned less-than.

Top module: `ctl_decoder`

## Requirements
- R1: With opcode 000000, function codes 100000/100001 give alu 0, 100010/100011 give alu 1, and 100100, 100101, 100110 and 100111 give alu 2, 3, 4 and 5. Each of these has a_sel 0, b_sel 0, wa_sel 0, wd_sel 1, rf_we 1, mem_we 0 and pc_sel 0.
- R2: With opcode 000000, function codes 000XXX are shifts. Bits [1:0] select the shift: 00 gives alu 6, 10 gives alu 7 and 11 gives alu 8. Bit 2 clear gives a_sel 1 (shamt) and bit 2 set gives a_sel 0 (Rs). All shifts have b_sel 0, wa_sel 0, wd_sel 1 and rf_we 1. Function codes 000001 and 000101 are illegal.
- R3: With opcode 000000, function 101010 gives alu 9 and 101011 gives alu 10. Both have a_sel 0, b_sel 0, wa_sel 0, wd_sel 1 and rf_we 1.
- R4: With opcode 000000, function 001000 (register jump) gives pc_sel 3 and rf_we 0. Function 001001 (register jump and link) gives pc_sel 3, wa_sel 0, wd_sel 0 and rf_we 1.
- R5: Opcodes 001000 to 001110 are immediate ALU operations. The low three opcode bits select the ALU code: 000 and 001 give 0, 010 gives 9, 011 gives 10, 100 gives 2, 101 gives 3 and 110 gives 4. All have a_sel 0, b_sel 1, wa_sel 1, wd_sel 1, rf_we 1 and pc_sel 0.
- R6: Opcode 001111 (load upper immediate) gives a_sel 2, b_sel 1, alu 6, wa_sel 1, wd_sel 1 and rf_we 1. Constant 16 on the A side is used by no other instruction.
- R7: Opcode 100011 (load word) gives a_sel 0, b_sel 1, alu 0, wa_sel 1, wd_sel 2, rf_we 1 and mem_we 0.
- R8: Opcode 101011 (store word) gives a_sel 0, b_sel 1, alu 0, mem_we 1, rf_we 0 and pc_sel 0. No other instruction raises mem_we.
- R9: Opcodes 000100 (branch if equal) and 000101 (branch if not equal) give alu 1, a_sel 0, b_sel 0 and rf_we 0. pc_sel is 1 when the zero flag is 1 for the first or 0 for the second, and 0 otherwise.
- R10: Opcode 000010 (jump) gives pc_sel 2 and rf_we 0. Opcode 000011 (jump and link) gives pc_sel 2, wa_sel 2, wd_sel 0 and rf_we 1. Register 31 is chosen by no other instruction.
- R11: Every opcode or function code not listed above raises bad_op_o, with pc_sel 4, wa_sel 3, wd_sel 0, rf_we 1 and mem_we 0. All listed encodings keep bad_op_o at 0.
- R12: The zero flag changes pc_sel only for the two branch opcodes. It has no effect on any output for any other instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Major opcode, instruction bits 31:26 |
| funct_i | input | 6 | Function field, instruction bits 5:0 |
| alu_zero_i | input | 1 | ALU result-is-zero flag, used to resolve branches |
| pc_sel_o | output | 3 | Next-PC source |
| wa_sel_o | output | 2 | Register write address source |
| a_sel_o | output | 2 | ALU A operand source |
| b_sel_o | output | 1 | ALU B operand source |
| wd_sel_o | output | 2 | Register write data source |
| alu_fn_o | output | 4 | ALU operation code |
| rf_we_o | output | 1 | Register-file write enable |
| mem_we_o | output | 1 | Data-memory write strobe |
| bad_op_o | output | 1 | Illegal-instruction indication |

## Verification
The assertions check, whenever the inputs are known, the relations between outputs and inputs that must hold for every encoding:
- a memory write comes only from the store opcode and never with a register write;
- an illegal-instruction flag always forces the trap fields;
- a taken branch only appears on a branch opcode whose condition matches the zero flag;
- constant 16 and register 31 are each tied to their single instruction.

Only the bench's scenarios can show the individual code mappings: each function code and opcode to its ALU operation and operand selects, the shift-source choice, and the exact set of encodings treated as illegal.

// File: rtl/ctl_pkg.sv
`timescale 1ns/1ps
package ctl_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int PCS_W  = 3;
    localparam int WAS_W  = 2;
    localparam int AS_W   = 2;
    localparam int WDS_W  = 2;
    localparam int ALU_W  = 4;
    localparam int GRP_W  = 3;
    localparam int SUB_W  = OP_W - GRP_W;

    // Opcode values that the datapath contract depends on
    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JMP     = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JAL     = 6'b000011;
    localparam logic [OP_W-1:0] OPC_BEQ     = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BNE     = 6'b000101;
    localparam logic [OP_W-1:0] OPC_LUI     = 6'b001111;
    localparam logic [OP_W-1:0] OPC_LDW     = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STW     = 6'b101011;
    localparam logic [GRP_W-1:0] GRP_IMM    = 3'b001;

    typedef enum logic [PCS_W-1:0] {
        PCS_SEQ    = 3'd0,
        PCS_BRANCH = 3'd1,
        PCS_JUMP   = 3'd2,
        PCS_REG    = 3'd3,
        PCS_TRAP   = 3'd4
    } pc_src_e;

    typedef enum logic [WAS_W-1:0] {
        WA_RD   = 2'd0,
        WA_RT   = 2'd1,
        WA_LINK = 2'd2,
        WA_XREG = 2'd3
    } wa_src_e;

    typedef enum logic [AS_W-1:0] {
        A_REG   = 2'd0,
        A_SHAMT = 2'd1,
        A_K16   = 2'd2
    } a_src_e;

    typedef enum logic {
        B_REG = 1'b0,
        B_IMM = 1'b1
    } b_src_e;

    typedef enum logic [WDS_W-1:0] {
        WD_LINK = 2'd0,
        WD_ALU  = 2'd1,
        WD_MEM  = 2'd2
    } wd_src_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_XOR  = 4'd4,
        ALU_NOR  = 4'd5,
        ALU_SLL  = 4'd6,
        ALU_SRL  = 4'd7,
        ALU_SRA  = 4'd8,
        ALU_SLT  = 4'd9,
        ALU_SLTU = 4'd10
    } alu_fn_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_kind_e;

    typedef struct packed {
        pc_src_e  pc_src;
        wa_src_e  wa;
        a_src_e   a;
        b_src_e   b;
        wd_src_e  wd;
        alu_fn_e  alu;
        logic     rf_we;
        logic     mem_we;
        br_kind_e br;
        logic     legal;
    } ctl_t;

    // Neutral control word: no side effects, not yet marked legal
    function automatic ctl_t ctl_idle();
        ctl_t c;
        c.pc_src = PCS_SEQ;
        c.wa     = WA_RD;
        c.a      = A_REG;
        c.b      = B_REG;
        c.wd     = WD_ALU;
        c.alu    = ALU_ADD;
        c.rf_we  = 1'b0;
        c.mem_we = 1'b0;
        c.br     = BR_NONE;
        c.legal  = 1'b0;
        return c;
    endfunction

    // Three-register ALU group, selected by the low function bits
    function automatic alu_fn_e arith_alu(input logic [2:0] sel);
        case (sel)
            3'b000, 3'b001: return ALU_ADD;
            3'b010, 3'b011: return ALU_SUB;
            3'b100:         return ALU_AND;
            3'b101:         return ALU_OR;
            3'b110:         return ALU_XOR;
            default:        return ALU_NOR;
        endcase
    endfunction

    // Immediate ALU group, selected by the low opcode bits (111 handled apart)
    function automatic alu_fn_e imm_alu(input logic [SUB_W-1:0] sel);
        case (sel)
            3'b010:  return ALU_SLT;
            3'b011:  return ALU_SLTU;
            3'b100:  return ALU_AND;
            3'b101:  return ALU_OR;
            3'b110:  return ALU_XOR;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/ctl_special_dec.sv
`timescale 1ns/1ps
module ctl_special_dec
    import ctl_pkg::*;
(
    input  logic [FN_W-1:0] funct_i,
    output ctl_t            ctl_o
);

    ctl_t c;

    always_comb begin
        c       = ctl_idle();
        c.rf_we = 1'b1;
        c.legal = 1'b1;
        casez (funct_i)
            6'b100???: begin
                c.alu = arith_alu(funct_i[2:0]);
            end
            6'b000???: begin
                // bit 2 picks a variable shift amount from Rs
                c.a = funct_i[2] ? A_REG : A_SHAMT;
                case (funct_i[1:0])
                    2'b00:   c.alu = ALU_SLL;
                    2'b10:   c.alu = ALU_SRL;
                    2'b11:   c.alu = ALU_SRA;
                    default: c.legal = 1'b0;
                endcase
            end
            6'b00100?: begin
                c.pc_src = PCS_REG;
                if (funct_i[0]) begin
                    c.wd = WD_LINK;
                end else begin
                    c.rf_we = 1'b0;
                end
            end
            6'b10101?: begin
                c.alu = funct_i[0] ? ALU_SLTU : ALU_SLT;
            end
            default: begin
                c.legal = 1'b0;
            end
        endcase
    end

    assign ctl_o = c;

endmodule

// File: rtl/ctl_main_dec.sv
`timescale 1ns/1ps
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    output ctl_t            ctl_o,
    output logic            special_o
);

    ctl_t c;
    logic is_imm;

    assign is_imm = (opcode_i[OP_W-1 -: GRP_W] == GRP_IMM);

    always_comb begin
        c         = ctl_idle();
        special_o = 1'b0;
        if (is_imm) begin
            c.legal = 1'b1;
            c.b     = B_IMM;
            c.wa    = WA_RT;
            c.rf_we = 1'b1;
            if (opcode_i == OPC_LUI) begin
                c.a   = A_K16;
                c.alu = ALU_SLL;
            end else begin
                c.alu = imm_alu(opcode_i[SUB_W-1:0]);
            end
        end else begin
            case (opcode_i)
                OPC_SPECIAL: begin
                    special_o = 1'b1;
                    c.legal   = 1'b1;
                end
                OPC_JMP: begin
                    c.legal  = 1'b1;
                    c.pc_src = PCS_JUMP;
                end
                OPC_JAL: begin
                    c.legal  = 1'b1;
                    c.pc_src = PCS_JUMP;
                    c.wa     = WA_LINK;
                    c.wd     = WD_LINK;
                    c.rf_we  = 1'b1;
                end
                OPC_BEQ, OPC_BNE: begin
                    c.legal = 1'b1;
                    c.alu   = ALU_SUB;
                    c.br    = opcode_i[0] ? BR_NE : BR_EQ;
                end
                OPC_LDW: begin
                    c.legal = 1'b1;
                    c.b     = B_IMM;
                    c.wa    = WA_RT;
                    c.wd    = WD_MEM;
                    c.rf_we = 1'b1;
                end
                OPC_STW: begin
                    c.legal  = 1'b1;
                    c.b      = B_IMM;
                    c.mem_we = 1'b1;
                end
                default: begin
                    c.legal = 1'b0;
                end
            endcase
        end
    end

    assign ctl_o = c;

endmodule

// File: rtl/ctl_pc_resolve.sv
`timescale 1ns/1ps
module ctl_pc_resolve
    import ctl_pkg::*;
(
    input  ctl_t ctl_i,
    input  logic zero_i,
    output ctl_t ctl_o
);

    ctl_t f;

    always_comb begin
        f = ctl_i;
        case (ctl_i.br)
            BR_EQ:   if (zero_i)  f.pc_src = PCS_BRANCH;
            BR_NE:   if (!zero_i) f.pc_src = PCS_BRANCH;
            default: ;
        endcase
        if (!ctl_i.legal) begin
            f.pc_src = PCS_TRAP;
            f.wa     = WA_XREG;
            f.wd     = WD_LINK;
            f.rf_we  = 1'b1;
            f.mem_we = 1'b0;
        end
    end

    assign ctl_o = f;

    // R12: without a branch kind, the PC source leaves this stage unchanged or trapped
    always_comb begin
        if (!$isunknown({ctl_i, zero_i}) && ctl_i.br == BR_NONE) begin
            assert_zero_ignored_R12: assert (ctl_o.pc_src == ctl_i.pc_src || ctl_o.pc_src == PCS_TRAP)
                else $error("zero flag altered pc source of a non-branch");
        end
    end

endmodule

// File: rtl/ctl_decoder.sv
`timescale 1ns/1ps
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    input  logic       alu_zero_i,
    output logic [2:0] pc_sel_o,
    output logic [1:0] wa_sel_o,
    output logic [1:0] a_sel_o,
    output logic       b_sel_o,
    output logic [1:0] wd_sel_o,
    output logic [3:0] alu_fn_o,
    output logic       rf_we_o,
    output logic       mem_we_o,
    output logic       bad_op_o
);

    ctl_t main_ctl;
    ctl_t spec_ctl;
    ctl_t pick_ctl;
    ctl_t fin_ctl;
    logic is_special;

    ctl_main_dec u_main (
        .opcode_i  (opcode_i),
        .ctl_o     (main_ctl),
        .special_o (is_special)
    );

    ctl_special_dec u_special (
        .funct_i (funct_i),
        .ctl_o   (spec_ctl)
    );

    assign pick_ctl = is_special ? spec_ctl : main_ctl;

    ctl_pc_resolve u_resolve (
        .ctl_i  (pick_ctl),
        .zero_i (alu_zero_i),
        .ctl_o  (fin_ctl)
    );

    assign pc_sel_o = fin_ctl.pc_src;
    assign wa_sel_o = fin_ctl.wa;
    assign a_sel_o  = fin_ctl.a;
    assign b_sel_o  = fin_ctl.b;
    assign wd_sel_o = fin_ctl.wd;
    assign alu_fn_o = fin_ctl.alu;
    assign rf_we_o  = fin_ctl.rf_we;
    assign mem_we_o = fin_ctl.mem_we;
    assign bad_op_o = ~fin_ctl.legal;

    always_comb begin
        if (!$isunknown({opcode_i, funct_i, alu_zero_i})) begin
            assert_store_only_R8: assert (!mem_we_o || (opcode_i == OPC_STW && !rf_we_o))
                else $error("memory write outside a store or with a register write");
            assert_trap_fields_R11: assert (!bad_op_o || (pc_sel_o == 3'd4 && wa_sel_o == 2'd3
                                              && wd_sel_o == 2'd0 && rf_we_o && !mem_we_o))
                else $error("illegal instruction without trap redirect");
            assert_branch_cond_R9: assert (pc_sel_o != 3'd1
                                           || (fin_ctl.br != BR_NONE
                                               && ((opcode_i == OPC_BEQ && alu_zero_i)
                                                   || (opcode_i == OPC_BNE && !alu_zero_i))))
                else $error("branch target chosen without a satisfied branch");
            assert_k16_lui_R6: assert (a_sel_o != 2'd2 || opcode_i == OPC_LUI)
                else $error("constant 16 operand outside load-upper");
            assert_link_reg_R10: assert (wa_sel_o != 2'd2 || opcode_i == OPC_JAL)
                else $error("register 31 written outside jump-and-link");
        end
    end

endmodule

// File: tb/test_ctl_decoder.sv
`timescale 1ns/1ps
module test_ctl_decoder;

    localparam int D = -1;  // field not checked

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic [5:0] funct  = 6'd0;
    logic       zero   = 1'b0;
    logic [2:0] pc_sel;
    logic [1:0] wa_sel, a_sel, wd_sel;
    logic       b_sel, rf_we, mem_we, bad_op;
    logic [3:0] alu_fn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    ctl_decoder i_ctl_decoder (
        .opcode_i   (opcode),
        .funct_i    (funct),
        .alu_zero_i (zero),
        .pc_sel_o   (pc_sel),
        .wa_sel_o   (wa_sel),
        .a_sel_o    (a_sel),
        .b_sel_o    (b_sel),
        .wd_sel_o   (wd_sel),
        .alu_fn_o   (alu_fn),
        .rf_we_o    (rf_we),
        .mem_we_o   (mem_we),
        .bad_op_o   (bad_op)
    );

    function automatic bit ok(input int act, input int exp);
        return (exp < 0) || (act == exp);
    endfunction

    task automatic chk(input string req, input logic [5:0] op, input logic [5:0] fn, input logic z,
                       input int e_pc, input int e_wa, input int e_a, input int e_b, input int e_wd,
                       input int e_alu, input int e_we, input int e_mwe, input int e_bad);
        @(negedge clk);
        opcode = op;
        funct  = fn;
        zero   = z;
        @(posedge clk);
        #1;
        checks++;
        if (!(ok(pc_sel, e_pc) && ok(wa_sel, e_wa) && ok(a_sel, e_a) && ok(b_sel, e_b)
              && ok(wd_sel, e_wd) && ok(alu_fn, e_alu) && ok(rf_we, e_we)
              && ok(mem_we, e_mwe) && ok(bad_op, e_bad))) begin
            errors++;
            $display("FAIL %s op=%b fn=%b z=%b actual pc=%0d wa=%0d a=%0d b=%0d wd=%0d alu=%0d we=%0d mwe=%0d bad=%0d expected pc=%0d wa=%0d a=%0d b=%0d wd=%0d alu=%0d we=%0d mwe=%0d bad=%0d",
                     req, op, fn, z, pc_sel, wa_sel, a_sel, b_sel, wd_sel, alu_fn, rf_we, mem_we, bad_op,
                     e_pc, e_wa, e_a, e_b, e_wd, e_alu, e_we, e_mwe, e_bad);
        end
    endtask

    // Reset state: all-zero instruction word decodes as a constant left shift
    task automatic t_reset_state();
        chk("R2 reset-state zero word", 6'b000000, 6'b000000, 1'b0, 0, 0, 1, 0, 1, 6, 1, 0, 0);
    endtask

    task automatic t_r1_arith();
        int exp_alu[8] = '{0, 0, 1, 1, 2, 3, 4, 5};
        for (int k = 0; k < 8; k++) begin
            chk("R1 register ALU", 6'b000000, {3'b100, 3'(k)}, 1'b0, 0, 0, 0, 0, 1, exp_alu[k], 1, 0, 0);
        end
    endtask

    task automatic t_r2_shift();
        chk("R2 sll",  6'b000000, 6'b000000, 1'b0, 0, 0, 1, 0, 1, 6, 1, 0, 0);
        chk("R2 srl",  6'b000000, 6'b000010, 1'b0, 0, 0, 1, 0, 1, 7, 1, 0, 0);
        chk("R2 sra",  6'b000000, 6'b000011, 1'b0, 0, 0, 1, 0, 1, 8, 1, 0, 0);
        chk("R2 sllv", 6'b000000, 6'b000100, 1'b0, 0, 0, 0, 0, 1, 6, 1, 0, 0);
        chk("R2 srlv", 6'b000000, 6'b000110, 1'b0, 0, 0, 0, 0, 1, 7, 1, 0, 0);
        chk("R2 srav", 6'b000000, 6'b000111, 1'b0, 0, 0, 0, 0, 1, 8, 1, 0, 0);
        chk("R2 illegal 000001", 6'b000000, 6'b000001, 1'b0, 4, 3, D, D, 0, D, 1, 0, 1);
        chk("R2 illegal 000101", 6'b000000, 6'b000101, 1'b0, 4, 3, D, D, 0, D, 1, 0, 1);
    endtask

    task automatic t_r3_setless();
        chk("R3 slt",  6'b000000, 6'b101010, 1'b0, 0, 0, 0, 0, 1, 9,  1, 0, 0);
        chk("R3 sltu", 6'b000000, 6'b101011, 1'b0, 0, 0, 0, 0, 1, 10, 1, 0, 0);
    endtask

    task automatic t_r4_regjump();
        chk("R4 jr",   6'b000000, 6'b001000, 1'b0, 3, D, D, D, D, D, 0, 0, 0);
        chk("R4 jalr", 6'b000000, 6'b001001, 1'b1, 3, 0, D, D, 0, D, 1, 0, 0);
    endtask

    task automatic t_r5_imm();
        int exp_alu[7] = '{0, 0, 9, 10, 2, 3, 4};
        for (int k = 0; k < 7; k++) begin
            chk("R5 immediate ALU", {3'b001, 3'(k)}, 6'b111111, 1'b0, 0, 1, 0, 1, 1, exp_alu[k], 1, 0, 0);
        end
    endtask

    task automatic t_r6_lui();
        chk("R6 lui", 6'b001111, 6'b000000, 1'b0, 0, 1, 2, 1, 1, 6, 1, 0, 0);
    endtask

    task automatic t_r7_r8_mem();
        chk("R7 load",  6'b100011, 6'b000000, 1'b0, 0, 1, 0, 1, 2, 0, 1, 0, 0);
        chk("R8 store", 6'b101011, 6'b000000, 1'b0, 0, D, 0, 1, D, 0, 0, 1, 0);
    endtask

    task automatic t_r9_branch();
        chk("R9 beq taken",     6'b000100, 6'b000000, 1'b1, 1, D, 0, 0, D, 1, 0, 0, 0);
        chk("R9 beq not taken", 6'b000100, 6'b000000, 1'b0, 0, D, 0, 0, D, 1, 0, 0, 0);
        chk("R9 bne taken",     6'b000101, 6'b000000, 1'b0, 1, D, 0, 0, D, 1, 0, 0, 0);
        chk("R9 bne not taken", 6'b000101, 6'b000000, 1'b1, 0, D, 0, 0, D, 1, 0, 0, 0);
    endtask

    task automatic t_r10_jump();
        chk("R10 j",   6'b000010, 6'b000000, 1'b0, 2, D, D, D, D, D, 0, 0, 0);
        chk("R10 jal", 6'b000011, 6'b000000, 1'b0, 2, 2, D, D, 0, D, 1, 0, 0);
    endtask

    task automatic t_r11_bad();
        logic [5:0] bad_ops[6] = '{6'b000001, 6'b000110, 6'b010000, 6'b100000, 6'b101000, 6'b111111};
        logic [5:0] bad_fns[4] = '{6'b001010, 6'b010000, 6'b101100, 6'b111111};
        foreach (bad_ops[k]) begin
            chk("R11 bad opcode", bad_ops[k], 6'b000000, 1'b0, 4, 3, D, D, 0, D, 1, 0, 1);
        end
        foreach (bad_fns[k]) begin
            chk("R11 bad function", 6'b000000, bad_fns[k], 1'b1, 4, 3, D, D, 0, D, 1, 0, 1);
        end
    endtask

    task automatic t_r12_zero_ignored();
        chk("R12 add with zero set",   6'b000000, 6'b100000, 1'b1, 0, 0, 0, 0, 1, 0, 1, 0, 0);
        chk("R12 load with zero set",  6'b100011, 6'b000000, 1'b1, 0, 1, 0, 1, 2, 0, 1, 0, 0);
        chk("R12 store with zero set", 6'b101011, 6'b000000, 1'b1, 0, D, 0, 1, D, 0, 0, 1, 0);
        chk("R12 jump with zero set",  6'b000010, 6'b000000, 1'b1, 2, D, D, D, D, D, 0, 0, 0);
        chk("R12 jr with zero set",    6'b000000, 6'b001000, 1'b1, 3, D, D, D, D, D, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_r1_arith();
        t_r2_shift();
        t_r3_setless();
        t_r4_regjump();
        t_r5_imm();
        t_r6_lui();
        t_r7_r8_mem();
        t_r9_branch();
        t_r10_jump();
        t_r11_bad();
        t_r12_zero_ignored();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule